// File: doc/BRIEF.md
# Programmable Interrupt Controller

This controller sits next to a processor core and gathers a parameterised set of interrupt lines (32 by default). Software sees two registers through a small special-register port: an enable mask and a pending-status word. Bit n of either register belongs to line n. Whenever some status bit is pending and its mask bit is set, a single registered request goes to the core.

A build parameter fixes how status behaves. In level mode, status simply mirrors the input lines and ignores writes. In edge mode, a rising input latches its status bit, and writing a one to that bit clears it. In legacy mode, any high input latches, and writing a zero to a bit clears it. A lowest-pending-line index, qualified by a valid flag, lets software service lines starting from line 0 and moving upward.

Top module: `irq_ctrl`

## Requirements
- R1: Synchronous reset clears the mask register, every latched status bit and the core request. `pend_valid` is 0 after reset.
- R2: A write with `reg_sel`=0 replaces the whole mask at the next clock edge. While `reg_sel`=0, `reg_rdata` shows the mask in the same cycle. A mask bit of 1 enables its line.
- R3: `core_irq` goes high one clock after the AND of status and mask becomes nonzero, and low one clock after it becomes zero. A pending line whose mask bit is 0 never raises it.
- R4: In level mode (`MODE`=PIC_LEVEL), reading with `reg_sel`=1 returns the current input lines, and writes with `reg_sel`=1 have no effect.
- R5: In edge mode (`MODE`=PIC_EDGE), a line that was sampled low at one clock edge and high at the next sets its status bit at that second edge. A line held high does not set the bit again. A status write (`reg_sel`=1) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R6: In legacy mode (`MODE`=PIC_LEGACY), every line sampled high sets its status bit, and the bit stays set after the line falls. A status write clears each bit written as 0 and keeps bits written as 1.
- R7: If a status write tries to clear a bit in the same cycle that the bit's set condition occurs (a rising edge in edge mode, a high level in legacy mode), the bit ends up set.
- R8: `pend_valid` is 1 exactly when status AND mask is nonzero. `pend_index` then gives the lowest-numbered such bit, so line 0 has the highest priority. When `pend_valid` is 0, `pend_index` is 0.
- R9: Line N-1 is reported by `pend_index` when it is the only enabled pending line, even while lower lines are pending but masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | N | Interrupt inputs, bit n is line n |
| reg_sel | input | 1 | Register select: 0 mask, 1 status |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | N | Write data |
| reg_rdata | output | N | Selected register, combinational |
| core_irq | output | 1 | Registered interrupt request to the core |
| pend_valid | output | 1 | Some enabled status bit is pending |
| pend_index | output | clog2(N) | Lowest enabled pending line |

## Verification
The checker assumes that the interrupt lines are synchronous to `clk` and are held low throughout reset, so that the edge detector starts from a known all-low history. It also assumes that reset lasts at least two cycles, because some properties look one and two samples back. The bench changes every input only on the falling edge and holds the lines at zero while reset is active. It then drives all three variants with the same stimulus, so that each variant's write rule is exercised on identical patterns.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [1:0] {
        PIC_LEVEL  = 2'd0,
        PIC_EDGE   = 2'd1,
        PIC_LEGACY = 2'd2
    } pic_mode_e;

    localparam logic SEL_MASK   = 1'b0;
    localparam logic SEL_STATUS = 1'b1;

    typedef struct packed {
        logic mask_wr;
        logic stat_wr;
    } reg_strobe_t;

    function automatic reg_strobe_t decode_strobe(input logic wr, input logic sel);
        reg_strobe_t s;
        s.mask_wr = wr && (sel == SEL_MASK);
        s.stat_wr = wr && (sel == SEL_STATUS);
        return s;
    endfunction

endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank
    import irq_ctrl_pkg::*;
#(
    parameter int        N    = 32,
    parameter pic_mode_e MODE = PIC_EDGE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    input  logic         stat_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status
);

    generate
        if (MODE == PIC_LEVEL) begin : g_level
            assign status = lines;
        end else if (MODE == PIC_EDGE) begin : g_edge
            logic [N-1:0] prev_q;
            logic [N-1:0] stat_q;
            logic [N-1:0] rise;
            logic [N-1:0] clr;
            assign rise = lines & ~prev_q;
            assign clr  = stat_wr ? wdata : '0;
            always_ff @(posedge clk) begin
                if (rst) begin
                    prev_q <= '0;
                    stat_q <= '0;
                end else begin
                    prev_q <= lines;
                    stat_q <= (stat_q & ~clr) | rise;
                end
            end
            assign status = stat_q;
        end else begin : g_legacy
            logic [N-1:0] stat_q;
            logic [N-1:0] keep;
            assign keep = stat_wr ? wdata : '1;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stat_q <= '0;
                end else begin
                    stat_q <= (stat_q & keep) | lines;
                end
            end
            assign status = stat_q;
        end
    endgenerate

endmodule

// File: rtl/irq_lowest_find.sv
module irq_lowest_find #(
    parameter int N  = 32,
    parameter int IW = 5
) (
    input  logic [N-1:0]  vec,
    output logic          valid,
    output logic [IW-1:0] index
);

    always_comb begin
        valid = |vec;
        index = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) index = IW'(i);
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int        N    = 32,
    parameter pic_mode_e MODE = PIC_EDGE,
    localparam int       IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  irq_lines,
    input  logic          reg_sel,
    input  logic          reg_wr,
    input  logic [N-1:0]  reg_wdata,
    output logic [N-1:0]  reg_rdata,
    output logic          core_irq,
    output logic          pend_valid,
    output logic [IW-1:0] pend_index
);

    reg_strobe_t  stb;
    logic [N-1:0] mask_q;
    logic [N-1:0] status_vec;
    logic [N-1:0] enabled;
    logic         irq_q;

    assign stb = decode_strobe(reg_wr, reg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (stb.mask_wr) begin
            mask_q <= reg_wdata;
        end
    end

    irq_status_bank #(.N(N), .MODE(MODE)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .lines   (irq_lines),
        .stat_wr (stb.stat_wr),
        .wdata   (reg_wdata),
        .status  (status_vec)
    );

    assign enabled = status_vec & mask_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |enabled;
    end
    assign core_irq = irq_q;

    irq_lowest_find #(.N(N), .IW(IW)) u_find (
        .vec   (enabled),
        .valid (pend_valid),
        .index (pend_index)
    );

    assign reg_rdata = (reg_sel == SEL_STATUS) ? status_vec : mask_q;

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int        N    = 32,
    parameter pic_mode_e MODE = PIC_EDGE,
    localparam int       IW   = (N > 1) ? $clog2(N) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic [N-1:0]  irq_lines,
    input logic          reg_sel,
    input logic          reg_wr,
    input logic [N-1:0]  reg_wdata,
    input logic [N-1:0]  reg_rdata,
    input logic          core_irq,
    input logic          pend_valid,
    input logic [IW-1:0] pend_index,
    input logic [N-1:0]  status,
    input logic [N-1:0]  mask
);

    logic [N-1:0] vis;
    logic [N-1:0] low;
    logic [N-1:0] idx_hot;
    assign vis     = status & mask;
    assign low     = vis & (~vis + 1'b1);
    assign idx_hot = N'(1) << pend_index;

    p_mask_write_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == SEL_MASK) |=> (mask == $past(reg_wdata)));

    p_irq_rise_r3: assert property (@(posedge clk) disable iff (rst)
        pend_valid |=> core_irq);

    p_irq_fall_r3: assert property (@(posedge clk) disable iff (rst)
        !pend_valid |=> !core_irq);

    p_pend_lowest_r8: assert property (@(posedge clk) disable iff (rst)
        pend_valid |-> (low == idx_hot));

    p_pend_none_r8: assert property (@(posedge clk) disable iff (rst)
        !pend_valid |-> (vis == '0 && pend_index == '0));

    generate
        if (MODE == PIC_LEVEL) begin : g_level
            p_level_mirror_r4: assert property (@(posedge clk) disable iff (rst)
                (reg_sel == SEL_STATUS) |-> (reg_rdata == irq_lines));
        end else if (MODE == PIC_EDGE) begin : g_edge
            p_edge_hold_r5: assert property (@(posedge clk) disable iff (rst)
                !(reg_wr && reg_sel == SEL_STATUS) |=>
                    ((status & $past(status)) == $past(status)));
            p_edge_wins_r7: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> ((status & $past(irq_lines) & ~$past(irq_lines, 2)) ==
                          ($past(irq_lines) & ~$past(irq_lines, 2))));
        end else begin : g_legacy
            p_legacy_hold_r6: assert property (@(posedge clk) disable iff (rst)
                !(reg_wr && reg_sel == SEL_STATUS) |=>
                    ((status & $past(status)) == $past(status)));
            p_legacy_wins_r7: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> ((status & $past(irq_lines)) == $past(irq_lines)));
        end
    endgenerate

endmodule

bind irq_ctrl irq_ctrl_chk #(.N(N), .MODE(MODE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .irq_lines  (irq_lines),
    .reg_sel    (reg_sel),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .core_irq   (core_irq),
    .pend_valid (pend_valid),
    .pend_index (pend_index),
    .status     (status_vec),
    .mask       (mask_q)
);

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
    import irq_ctrl_pkg::*;

    localparam int N  = 32;
    localparam int IW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic         rst;
    logic [N-1:0] lines;
    logic         sel;
    logic         wr;
    logic [N-1:0] wd;

    logic [N-1:0]  rd_o [3];
    logic          irq_o [3];
    logic          pv_o [3];
    logic [IW-1:0] pi_o [3];

    irq_ctrl #(.N(N), .MODE(PIC_LEVEL)) dut_lvl_i (
        .clk(clk), .rst(rst), .irq_lines(lines), .reg_sel(sel), .reg_wr(wr),
        .reg_wdata(wd), .reg_rdata(rd_o[0]), .core_irq(irq_o[0]),
        .pend_valid(pv_o[0]), .pend_index(pi_o[0]));
    irq_ctrl #(.N(N), .MODE(PIC_EDGE)) dut_i (
        .clk(clk), .rst(rst), .irq_lines(lines), .reg_sel(sel), .reg_wr(wr),
        .reg_wdata(wd), .reg_rdata(rd_o[1]), .core_irq(irq_o[1]),
        .pend_valid(pv_o[1]), .pend_index(pi_o[1]));
    irq_ctrl #(.N(N), .MODE(PIC_LEGACY)) dut_leg_i (
        .clk(clk), .rst(rst), .irq_lines(lines), .reg_sel(sel), .reg_wr(wr),
        .reg_wdata(wd), .reg_rdata(rd_o[2]), .core_irq(irq_o[2]),
        .pend_valid(pv_o[2]), .pend_index(pi_o[2]));

    typedef struct {
        string          tag;
        logic [3*N-1:0] rd;
        logic [2:0]     irq;
        logic [2:0]     pv;
        logic [3*IW-1:0] pi;
    } exp_t;

    exp_t q[$];
    int n_chk  = 0;
    int n_fail = 0;

    // bench reference state
    logic [N-1:0] m_mask, m_edge, m_leg, m_prev;

    task automatic check(input string tag, input string what, input int k,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s variant%0d actual=%h expected=%h", tag, what, k, act, exp);
        end
    endtask

    task automatic step(input logic [N-1:0] ln, input logic w, input logic s,
                        input logic [N-1:0] d, input string tag);
        exp_t e;
        logic [N-1:0] ov [3];
        logic [N-1:0] nv [3];
        logic [N-1:0] rise;
        @(negedge clk);
        lines = ln; wr = w; sel = s; wd = d;
        ov[0] = ln; ov[1] = m_edge; ov[2] = m_leg;
        e.tag = tag;
        for (int k = 0; k < 3; k++) e.irq[k] = |(ov[k] & m_mask);
        rise   = ln & ~m_prev;
        m_prev = ln;
        if (w && s) begin
            m_edge = (m_edge & ~d) | rise;
            m_leg  = (m_leg & d) | ln;
        end else begin
            m_edge = m_edge | rise;
            m_leg  = m_leg | ln;
        end
        if (w && !s) m_mask = d;
        nv[0] = ln; nv[1] = m_edge; nv[2] = m_leg;
        for (int k = 0; k < 3; k++) begin
            logic [N-1:0] vv;
            logic [IW-1:0] idx;
            logic found;
            vv = nv[k] & m_mask;
            idx = '0;
            found = 1'b0;
            for (int b = 0; b < N; b++) begin
                if (!found && vv[b]) begin
                    idx = IW'(b);
                    found = 1'b1;
                end
            end
            e.rd[k*N +: N]   = s ? nv[k] : m_mask;
            e.pv[k]          = found;
            e.pi[k*IW +: IW] = idx;
        end
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                for (int k = 0; k < 3; k++) begin
                    check(e.tag, "reg_rdata", k, rd_o[k], e.rd[k*N +: N]);
                    check(e.tag, "core_irq", k, N'(irq_o[k]), N'(e.irq[k]));
                    check(e.tag, "pend_valid", k, N'(pv_o[k]), N'(e.pv[k]));
                    check(e.tag, "pend_index", k, N'(pi_o[k]), N'(e.pi[k*IW +: IW]));
                end
            end
        end
    end

    bit done = 1'b0;
    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] lf;
        rst = 1'b1; lines = '0; wr = 1'b0; sel = 1'b0; wd = '0;
        m_mask = '0; m_edge = '0; m_leg = '0; m_prev = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        step('0, 0, 0, '0, "R1");                         // mask reads zero
        step('0, 0, 1, '0, "R1");                         // status reads zero
        step('0, 1, 0, 32'h8000_00F0, "R2");              // mask write
        step('0, 0, 0, '0, "R2");
        step(32'h0000_0001, 0, 1, '0, "R3");              // masked line: no request
        step(32'h0000_0020, 0, 1, '0, "R3");              // enabled line 5
        step(32'h0000_0020, 0, 1, '0, "R3");
        step(32'h0000_0020, 1, 1, 32'h0000_0020, "R5");   // edge clear while held high
        step(32'h0000_0020, 0, 1, '0, "R5");
        step(32'h0000_0020, 1, 1, 32'hFFFF_FFFF, "R4");   // level ignores write
        step('0, 1, 1, ~32'h0000_0020, "R6");             // legacy clear by zero
        step('0, 1, 1, 32'hFFFF_FFFF, "R6");              // ones keep
        step('0, 0, 1, '0, "R6");
        step(32'h8000_0080, 0, 1, '0, "R8");              // lines 7 and 31
        step('0, 0, 1, '0, "R8");
        step('0, 1, 1, ~32'h0000_0080, "R9");             // legacy drops 7, 31 left
        step('0, 0, 1, '0, "R9");
        step('0, 1, 1, 32'hFFFF_FFFF, "R5");              // edge clears all
        step('0, 0, 1, '0, "R9");
        step(32'h0000_0010, 1, 1, 32'h0000_0010, "R7");   // edge: rise vs clear
        step(32'h0000_0010, 1, 1, '0, "R7");              // legacy: high vs clear
        step(32'h0000_0010, 0, 1, '0, "R7");
        step('0, 1, 0, '0, "R3");                         // mask all off
        step('0, 0, 1, '0, "R3");
        step('0, 0, 1, '0, "R3");
        lf = 32'hACE1_1234;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf & 32'h0F0F_F00F, lf[3], lf[9], ~lf, "R8");
        end
        step('0, 0, 0, '0, "R8");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule